// File: doc/BRIEF.md
# Coalescing Interrupt Status Controller

This block collects interrupt causes for a network interface and turns them into one level-sensitive interrupt line toward the CPU. Internal sources set cause bits with a post request, and software removes them with a clear request. A mask register selects which causes can interrupt. A programmable delay lets several causes coalesce into one interrupt. Causes in a fixed urgent group skip that delay.

At most one CPU interrupt is outstanding at a time. Once the line is raised, further deadlines do not add a second one. The line stays up until the CPU acknowledges it, or until the interrupt is withdrawn because no unmasked cause is left. A global enable input gates all scheduling. Requests that touch the reserved cause bits are rejected and flagged.

Cause bit assignment used throughout:

| Bit | Cause |
|-----|-------|
| 0 | receive done |
| 1 | receive data done |
| 2 | receive FIFO high |
| 3 | transmit done |
| 4 | transmit data done |
| 5 | transmit FIFO low |
| 31:8 | reserved |

The urgent group is bits 2 and 5.

Top module: `irq_coalesce_top`

## Requirements
- R1: A legal post request sets the given bits in `status`. The new value is visible the cycle after the request; bits already set stay set.
- R2: A legal clear request removes the given bits from `status`. When a legal post and a legal clear arrive in the same cycle, the clear is applied after the post, so a bit in both ends up 0.
- R3: A post or clear whose bits touch the reserved group (bits 31:8) is ignored entirely, with no state or scheduling change. `resErr` is high for exactly the one cycle after the request.
- R4: After reset, `status` is 0, `mask` is 0x0000_0026, the delay is 0, and `irq` and `resErr` are low.
- R5: With the enable high, consider a legal post that leaves status AND mask nonzero, where no urgent bit is set in status AND mask, and the delay D is nonzero. `irq` rises exactly D clock edges after the edge that takes the post, unless an earlier event raises it first.
- R6: When such a post leaves an urgent bit (bit 2 or 5) set in status AND mask, or when D is 0, `irq` rises on the edge that takes the post.
- R7: A new delayed request whose deadline would be later than a deadline already scheduled leaves the existing deadline unchanged. A request with an earlier deadline replaces it.
- R8: While an interrupt is pending, a further deadline or immediate post creates no second interrupt. After an acknowledge, `irq` stays low until a new post, mask change or enable rise schedules one.
- R9: `ack` forces `irq` low combinationally in the same cycle and clears the pending interrupt at the next edge. A new interrupt fired on that same edge takes precedence.
- R10: A legal clear that leaves status AND mask equal to zero withdraws the pending interrupt and any scheduled deadline at that edge.
- R11: Writing a mask equal to the current mask changes nothing. Writing a different mask that leaves status AND mask nonzero raises `irq` on that edge, without delay, if the enable is high.
- R12: While `intEnable` is low, nothing is scheduled, and any pending interrupt or deadline is dropped. A rise of `intEnable` while status AND mask is nonzero raises `irq` on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| intEnable | input | 1 | Global interrupt enable level |
| postValid | input | 1 | Post request strobe |
| postBits | input | 32 | Cause bits to set |
| clearValid | input | 1 | Clear request strobe |
| clearBits | input | 32 | Cause bits to remove |
| maskWrite | input | 1 | Mask write strobe |
| maskData | input | 32 | New mask value |
| delayWrite | input | 1 | Delay write strobe, effective from the next cycle |
| delayData | input | 16 | Coalescing delay in clock cycles |
| ack | input | 1 | CPU acknowledge of the interrupt |
| irq | output | 1 | Interrupt line to the CPU |
| status | output | 32 | Current cause status |
| mask | output | 32 | Current mask |
| resErr | output | 1 | One-cycle flag for a rejected reserved-bit request |

## Verification
Directed sequences are used first. They post a non-urgent cause under a nonzero delay to pin the exact rise edge. They post an urgent cause, and also use a zero delay, to show the bypass. A second request is posted later or earlier than a live deadline, which separates keeping the deadline from replacing it. A clear that leaves no masked cause shows that the deadline is withdrawn rather than merely masked. Mask writes of the same and of a different value are checked against each other. The enable is toggled with active causes, and reserved bits are mixed into otherwise legal requests. A long random run then interleaves posts, clears, mask and delay writes, acknowledges and enable changes. That run exposes orderings between simultaneous events that the directed cases do not reach.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;

  // Event strobes the status datapath hands to the scheduling control.
  typedef struct packed {
    logic postAcc;    // legal post taken this cycle
    logic clearAcc;   // legal clear taken this cycle
    logic maskChg;    // mask write with a different value
    logic anyActive;  // next status AND next mask is nonzero
    logic urgent;     // next status AND next mask hits the urgent group
    logic delayZero;  // programmed delay is zero
  } dpEvt_t;

endpackage

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_coal_pkg::*;
#(
  parameter int          CAUSE_W     = 32,
  parameter int          DLY_W       = 16,
  parameter logic [31:0] RES_MASK    = 32'hFFFF_FF00,
  parameter logic [31:0] URGENT_MASK = 32'h0000_0024,
  parameter logic [31:0] MASK_RST    = 32'h0000_0026
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               postValid,
  input  logic [CAUSE_W-1:0] postBits,
  input  logic               clearValid,
  input  logic [CAUSE_W-1:0] clearBits,
  input  logic               maskWrite,
  input  logic [CAUSE_W-1:0] maskData,
  input  logic               delayWrite,
  input  logic [DLY_W-1:0]   delayData,
  output logic [CAUSE_W-1:0] status,
  output logic [CAUSE_W-1:0] mask,
  output logic [DLY_W-1:0]   delayVal,
  output logic               resErr,
  output dpEvt_t             evt
);

  localparam logic [CAUSE_W-1:0] RES_W    = RES_MASK[CAUSE_W-1:0];
  localparam logic [CAUSE_W-1:0] URGENT_W = URGENT_MASK[CAUSE_W-1:0];
  localparam logic [CAUSE_W-1:0] MRST_W   = MASK_RST[CAUSE_W-1:0];

  logic [CAUSE_W-1:0] statusQ, maskQ, nextStatus, nextMask, activeBits;
  logic [DLY_W-1:0]   delayQ;
  logic               errQ;
  logic               postBad, clearBad, postOk, clearOk;

  assign postBad  = postValid  && ((postBits  & RES_W) != '0);
  assign clearBad = clearValid && ((clearBits & RES_W) != '0);
  assign postOk   = postValid  && !postBad;
  assign clearOk  = clearValid && !clearBad;

  // Per-bit status update: the clear is applied after the post.
  for (genvar i = 0; i < CAUSE_W; i++) begin : g_bit
    assign nextStatus[i] = (clearOk && clearBits[i]) ? 1'b0 :
                           (postOk  && postBits[i])  ? 1'b1 : statusQ[i];
  end

  assign nextMask   = maskWrite ? maskData : maskQ;
  assign activeBits = nextStatus & nextMask;

  always_comb begin
    evt.postAcc   = postOk;
    evt.clearAcc  = clearOk;
    evt.maskChg   = maskWrite && (maskData != maskQ);
    evt.anyActive = (activeBits != '0);
    evt.urgent    = ((activeBits & URGENT_W) != '0);
    evt.delayZero = (delayQ == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= MRST_W;
      delayQ  <= '0;
      errQ    <= 1'b0;
    end else begin
      statusQ <= nextStatus;
      maskQ   <= nextMask;
      if (delayWrite) delayQ <= delayData;
      errQ    <= postBad || clearBad;
    end
  end

  assign status   = statusQ;
  assign mask     = maskQ;
  assign delayVal = delayQ;
  assign resErr   = errQ;

  p_post_or_r1: assert property (@(posedge clk) disable iff (!rstN)
    (postValid && ((postBits & RES_W) == '0) && !clearValid)
      |=> ((statusQ & $past(postBits)) == $past(postBits)));

  p_res_post_r3: assert property (@(posedge clk) disable iff (!rstN)
    (postValid && ((postBits & RES_W) != '0) && !clearValid)
      |=> (statusQ == $past(statusQ)));

  p_res_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clearValid && ((clearBits & RES_W) != '0)) |=> errQ);

  p_same_mask_r11: assert property (@(posedge clk) disable iff (!rstN)
    (maskWrite && (maskData == maskQ)) |=> $stable(maskQ));

endmodule

// File: rtl/irq_sched_ctrl.sv
module irq_sched_ctrl
  import irq_coal_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intEnable,
  input  logic             ack,
  input  dpEvt_t           evt,
  input  logic [DLY_W-1:0] delayVal,
  output logic             pending
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic             enPrev, timerOn, pendQ;
  logic [DLY_W-1:0] timerCnt;
  logic             enRose, req, immediate, withdraw, expire, fire, loadNew;

  assign enRose    = intEnable && !enPrev;
  assign req       = intEnable && evt.anyActive &&
                     (evt.postAcc || evt.maskChg || enRose);
  assign immediate = evt.maskChg || enRose || evt.urgent || evt.delayZero;
  assign withdraw  = !intEnable || (evt.clearAcc && !evt.anyActive);
  assign expire    = timerOn && (timerCnt == ONE);
  assign fire      = !withdraw && ((req && immediate) || expire);
  // A later deadline never displaces one that is already scheduled.
  assign loadNew   = req && !immediate && (!timerOn || (delayVal < timerCnt));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enPrev   <= 1'b0;
      timerOn  <= 1'b0;
      timerCnt <= '0;
      pendQ    <= 1'b0;
    end else begin
      enPrev <= intEnable;
      if (withdraw || fire) begin
        timerOn  <= 1'b0;
        timerCnt <= '0;
      end else if (loadNew) begin
        timerOn  <= 1'b1;
        timerCnt <= delayVal;
      end else if (timerOn) begin
        timerCnt <= timerCnt - ONE;
      end
      if (withdraw)  pendQ <= 1'b0;
      else if (fire) pendQ <= 1'b1;
      else if (ack)  pendQ <= 1'b0;
    end
  end

  assign pending = pendQ;

  p_timer_live_r5: assert property (@(posedge clk) disable iff (!rstN)
    timerOn |-> (timerCnt != '0));

  p_urgent_now_r6: assert property (@(posedge clk) disable iff (!rstN)
    (intEnable && evt.postAcc && evt.anyActive && evt.urgent) |=> pendQ);

  p_withdraw_r10: assert property (@(posedge clk) disable iff (!rstN)
    (evt.clearAcc && !evt.anyActive) |=> !pendQ);

  p_disabled_r12: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |=> (!pendQ && !timerOn));

endmodule

// File: rtl/irq_coalesce_top.sv
module irq_coalesce_top
  import irq_coal_pkg::*;
#(
  parameter int          CAUSE_W     = 32,
  parameter int          DLY_W       = 16,
  parameter logic [31:0] RES_MASK    = 32'hFFFF_FF00,
  parameter logic [31:0] URGENT_MASK = 32'h0000_0024,
  parameter logic [31:0] MASK_RST    = 32'h0000_0026
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               intEnable,
  input  logic               postValid,
  input  logic [CAUSE_W-1:0] postBits,
  input  logic               clearValid,
  input  logic [CAUSE_W-1:0] clearBits,
  input  logic               maskWrite,
  input  logic [CAUSE_W-1:0] maskData,
  input  logic               delayWrite,
  input  logic [DLY_W-1:0]   delayData,
  input  logic               ack,
  output logic               irq,
  output logic [CAUSE_W-1:0] status,
  output logic [CAUSE_W-1:0] mask,
  output logic               resErr
);

  dpEvt_t           evt;
  logic [DLY_W-1:0] delayVal;
  logic             pending;

  irq_status_dp #(
    .CAUSE_W(CAUSE_W), .DLY_W(DLY_W), .RES_MASK(RES_MASK),
    .URGENT_MASK(URGENT_MASK), .MASK_RST(MASK_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .postValid(postValid), .postBits(postBits),
    .clearValid(clearValid), .clearBits(clearBits),
    .maskWrite(maskWrite), .maskData(maskData),
    .delayWrite(delayWrite), .delayData(delayData),
    .status(status), .mask(mask), .delayVal(delayVal),
    .resErr(resErr), .evt(evt)
  );

  irq_sched_ctrl #(.DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .intEnable(intEnable), .ack(ack),
    .evt(evt), .delayVal(delayVal), .pending(pending)
  );

  // Acknowledge drops the line in the same cycle (R9).
  assign irq = pending && !ack;

  p_ack_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> !irq);

endmodule

// File: tb/tb_irq_coalesce_top.sv
module tb_irq_coalesce_top;

  localparam logic [31:0] RES = 32'hFFFF_FF00;
  localparam logic [31:0] URG = 32'h0000_0024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        intEnable = 1'b0;
  logic        postValid = 1'b0, clearValid = 1'b0, maskWrite = 1'b0;
  logic        delayWrite = 1'b0, ack = 1'b0;
  logic [31:0] postBits = '0, clearBits = '0, maskData = '0;
  logic [15:0] delayData = '0;
  logic        irq, resErr;
  logic [31:0] status, mask;

  int nChecks = 0;
  int nFails  = 0;
  string curReq = "R4";

  // Reference model state
  logic [31:0] mStatus, mMask;
  logic [15:0] mDelay, mCnt;
  logic        mTimerOn, mPend, mErr, mEnPrev;

  always #5 clk = ~clk;

  irq_coalesce_top dut (
    .clk(clk), .rstN(rstN), .intEnable(intEnable),
    .postValid(postValid), .postBits(postBits),
    .clearValid(clearValid), .clearBits(clearBits),
    .maskWrite(maskWrite), .maskData(maskData),
    .delayWrite(delayWrite), .delayData(delayData),
    .ack(ack), .irq(irq), .status(status), .mask(mask), .resErr(resErr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic modelReset();
    mStatus = '0; mMask = 32'h26; mDelay = '0; mCnt = '0;
    mTimerOn = 0; mPend = 0; mErr = 0; mEnPrev = 0;
  endtask

  // Next-state model written from the requirements.
  task automatic modelStep();
    logic pOk, cOk, pBad, cBad, mChg, rose, req, imm, wd, expire, fire;
    logic [31:0] ns, nm, act;
    pBad = postValid && ((postBits & RES) != 0);
    cBad = clearValid && ((clearBits & RES) != 0);
    pOk  = postValid && !pBad;
    cOk  = clearValid && !cBad;
    ns = mStatus;
    if (pOk) ns = ns | postBits;
    if (cOk) ns = ns & ~clearBits;
    nm   = maskWrite ? maskData : mMask;
    mChg = maskWrite && (maskData != mMask);
    act  = ns & nm;
    rose = intEnable && !mEnPrev;
    req  = intEnable && (act != 0) && (pOk || mChg || rose);
    imm  = mChg || rose || ((act & URG) != 0) || (mDelay == 0);
    wd   = !intEnable || (cOk && act == 0);
    expire = mTimerOn && (mCnt == 1);
    fire = !wd && ((req && imm) || expire);
    if (wd || fire) begin
      mTimerOn = 0; mCnt = 0;
    end else if (req && !imm && (!mTimerOn || mDelay < mCnt)) begin
      mTimerOn = 1; mCnt = mDelay;
    end else if (mTimerOn) begin
      mCnt = mCnt - 1;
    end
    if (wd) mPend = 0;
    else if (fire) mPend = 1;
    else if (ack) mPend = 0;
    mErr = pBad || cBad;
    mStatus = ns; mMask = nm;
    if (delayWrite) mDelay = delayData;
    mEnPrev = intEnable;
  endtask

  // One clock: check comb irq, advance, compare, release strobes.
  task automatic tick();
    #1;
    chk({curReq, " irq/ack"}, {31'd0, irq}, {31'd0, mPend && !ack});
    @(posedge clk);
    modelStep();
    #2;
    chk({curReq, " status"}, status, mStatus);
    chk({curReq, " mask"}, mask, mMask);
    chk({curReq, " resErr"}, {31'd0, resErr}, {31'd0, mErr});
    chk({curReq, " irq"}, {31'd0, irq}, {31'd0, mPend && !ack});
    postValid = 0; clearValid = 0; maskWrite = 0; delayWrite = 0; ack = 0;
  endtask

  task automatic doPost(logic [31:0] b);
    postValid = 1; postBits = b; tick();
  endtask
  task automatic doClear(logic [31:0] b);
    clearValid = 1; clearBits = b; tick();
  endtask
  task automatic doDelay(logic [15:0] d);
    delayWrite = 1; delayData = d; tick();
  endtask
  task automatic doAck();
    ack = 1; #1;
    chk("R9 comb drop", {31'd0, irq}, 32'd0);
    tick();
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // R4 reset state
    curReq = "R4";
    chk("R4 status", status, 32'h0);
    chk("R4 mask", mask, 32'h26);
    chk("R4 irq", {31'd0, irq}, 32'd0);
    chk("R4 resErr", {31'd0, resErr}, 32'd0);
    intEnable = 1; tick();

    // R1 / R5: delayed non-urgent post, D = 4
    curReq = "R5";
    doDelay(16'd4);
    doPost(32'h02);
    chk("R1 post sets bit", status, 32'h02);
    chk("R5 low at +0", {31'd0, irq}, 32'd0);
    tick(); tick(); tick();
    chk("R5 low at +3", {31'd0, irq}, 32'd0);
    tick();
    chk("R5 high at +4", {31'd0, irq}, 32'd1);

    // R9 / R8 acknowledge, no repost
    curReq = "R9";
    doAck();
    chk("R9 low after ack", {31'd0, irq}, 32'd0);
    curReq = "R8";
    repeat (6) tick();
    chk("R8 stays low after ack", {31'd0, irq}, 32'd0);

    // R2 clear, and post+clear together
    curReq = "R2";
    doClear(32'h02);
    chk("R2 clear", status, 32'h0);
    postValid = 1; postBits = 32'h01; clearValid = 1; clearBits = 32'h01; tick();
    chk("R2 clear after post", status, 32'h0);

    // R3 reserved bits
    curReq = "R3";
    doPost(32'h100);
    chk("R3 post ignored", status, 32'h0);
    chk("R3 flag", {31'd0, resErr}, 32'd1);
    tick();
    chk("R3 flag one cycle", {31'd0, resErr}, 32'd0);
    doPost(32'h08);
    doClear(32'h8000_0008);
    chk("R3 clear ignored", status, 32'h08);

    // R6 urgent bypass and zero delay
    curReq = "R6";
    doPost(32'h04);
    chk("R6 urgent immediate", {31'd0, irq}, 32'd1);
    doAck();
    doClear(32'h0C);
    doDelay(16'd0);
    doPost(32'h02);
    chk("R6 zero delay immediate", {31'd0, irq}, 32'd1);
    curReq = "R10";
    doClear(32'h02);
    chk("R10 withdraw pending", {31'd0, irq}, 32'd0);

    // R7 later deadline kept
    curReq = "R7";
    doDelay(16'd10);
    doPost(32'h02);
    tick(); tick(); tick();
    doDelay(16'd20);
    doPost(32'h02);
    repeat (4) tick();
    chk("R7 not yet", {31'd0, irq}, 32'd0);
    tick();
    chk("R7 kept earlier deadline", {31'd0, irq}, 32'd1);
    doAck(); doClear(32'h02);
    // earlier deadline replaces
    doDelay(16'd20);
    doPost(32'h02);
    doDelay(16'd3);
    doPost(32'h02);
    tick(); tick();
    chk("R7 replace not yet", {31'd0, irq}, 32'd0);
    tick();
    chk("R7 replaced by earlier", {31'd0, irq}, 32'd1);
    doAck(); doClear(32'h02);

    // R10 deadline withdrawn by clear
    curReq = "R10";
    doDelay(16'd6);
    doPost(32'h02);
    tick(); tick();
    doClear(32'h02);
    repeat (8) tick();
    chk("R10 deadline withdrawn", {31'd0, irq}, 32'd0);

    // R11 mask writes
    curReq = "R11";
    doPost(32'h08);
    maskWrite = 1; maskData = 32'h26; tick();
    chk("R11 same mask no post", {31'd0, irq}, 32'd0);
    maskWrite = 1; maskData = 32'h0E; tick();
    chk("R11 new mask posts", {31'd0, irq}, 32'd1);
    chk("R11 mask value", mask, 32'h0E);
    doAck();
    maskWrite = 1; maskData = 32'h0E; tick();
    chk("R11 repeat mask no post", {31'd0, irq}, 32'd0);
    doClear(32'h08);
    maskWrite = 1; maskData = 32'h26; tick();

    // R12 enable gating
    curReq = "R12";
    intEnable = 0;
    doDelay(16'd0);
    doPost(32'h02);
    repeat (3) tick();
    chk("R12 disabled no irq", {31'd0, irq}, 32'd0);
    intEnable = 1; tick();
    chk("R12 enable rise posts", {31'd0, irq}, 32'd1);
    intEnable = 0; tick();
    chk("R12 disable drops", {31'd0, irq}, 32'd0);
    intEnable = 1; tick();
    doAck(); doClear(32'h02);

    // R8 no second interrupt while pending
    curReq = "R8";
    doPost(32'h02);
    doPost(32'h04);
    chk("R8 still one pending", {31'd0, irq}, 32'd1);
    doAck();
    repeat (3) tick();
    chk("R8 no second irq", {31'd0, irq}, 32'd0);
    doClear(32'h06);

    // Random phase
    curReq = "R1/R2/R5/R7 random";
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 6 == 0) begin
        postValid = 1;
        postBits = ($urandom & 32'h3F) |
                   (($urandom % 20 == 0) ? (32'h100 << ($urandom % 24)) : 32'h0);
      end
      if ($urandom % 7 == 0) begin
        clearValid = 1;
        clearBits = ($urandom & 32'h3F) |
                    (($urandom % 20 == 0) ? (32'h100 << ($urandom % 24)) : 32'h0);
      end
      if ($urandom % 40 == 0) begin
        maskWrite = 1; maskData = $urandom & 32'h3F;
      end
      if ($urandom % 30 == 0) begin
        delayWrite = 1; delayData = 16'($urandom % 9);
      end
      if ($urandom % 60 == 0) intEnable = ~intEnable;
      if ($urandom % 5 == 0) ack = 1;
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule